// File: doc/BRIEF.md
# T1 Receive Status and Interrupt Control Unit

This unit sits beside the framing logic of a T1 receiver and turns single-cycle event pulses into per-event error counts. It also holds a small control word, raises an interrupt request, and drives the loss indicator pin. Six event types are counted: change of frame alignment, loss of frame alignment, bipolar violation, CRC error, severely errored frame and multiframe out of sync. Each count saturates and never wraps. Counting can run freely, or in a mode where the visible counts change only on a one-second tick. Detecting the events is the job of other logic.

Software drives the control word through a write strobe with a data byte. Two of its bits take effect at the write and are not stored: the soft reset bit and the interrupt acknowledge bit. Four bits are stored: suspend, counter clear, sampling mode and loss select. Interrupt sources set sticky status bits. The IRQ pin is active low. It is modelled as a data pin plus an output enable, and a released pin has its enable low.

Top module: `framer_stat_ctrl`

## Requirements
- R1: A write with data bit 0 set acts as a hardware reset at that clock edge. All counts, holding values, status bits and stored control bits go to zero, and any other bits in that write are ignored. Read-back of bit 0 is always 0.
- R2: With sampling mode off, a pulse on `ev_pulse[i]` increments count `i` by one at that edge. Count `i` is bits `[i*CNT_W +: CNT_W]` of `cnt_flat`. Event index 0 is change of alignment, 1 loss of alignment, 2 bipolar violation, 3 CRC error, 4 severely errored frame and 5 multiframe out of sync.
- R3: A count at 2^CNT_W-1 stays there on further events.
- R4: While stored bit 3 (counter clear) is one, every count reads zero and events are ignored. After the bit is written back to zero, counting restarts from zero.
- R5: While stored bit 4 (sampling mode) is one, each `sec_tick` copies the running count into the visible count. The copy includes an event in the same cycle, and the running count then restarts at zero. Between ticks the visible counts do not change.
- R6: A pulse on `irq_src[j]` sets sticky bit `irq_stat[j]`. While any status bit is set and interrupts are not suspended, `irq_oe` is 1 and `irq_n` is 0.
- R7: While stored bit 2 (suspend) is one, `irq_oe` is 0, `irq_n` is 1, and source pulses do not set status bits. Status bits already set are kept.
- R8: A write with bit 1 (acknowledge) set clears every status bit at that edge. A source pulse in the same cycle still sets its bit. Read-back of bit 1 is always 0.
- R9: With stored bit 5 (loss select) at one, `los_pin` follows `los_state` alone. With it at zero, `los_pin` is `los_state | lof_state`.
- R10: After hardware reset every count is 0, `ctl_rdata` is 0, `irq_stat` is 0, `irq_oe` is 0 and `irq_n` is 1. A write stores bits 2 to 5, and `ctl_rdata` returns those bits in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | NUM_EV | Single-cycle error event pulses, one per counter |
| sec_tick | input | 1 | One-second tick pulse |
| irq_src | input | N_IRQ | Interrupt source pulses |
| los_state | input | 1 | Loss of signal level |
| lof_state | input | 1 | Loss of frame alignment level |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word read-back |
| cnt_flat | output | NUM_EV*CNT_W | Visible counts, packed by event index |
| irq_stat | output | N_IRQ | Sticky interrupt status bits |
| irq_n | output | 1 | Interrupt request, active low when driven |
| irq_oe | output | 1 | Output enable for irq_n; 0 means high impedance |
| los_pin | output | 1 | Loss indicator pin |

## Verification
The bench builds the unit with CNT_W set to 4 and N_IRQ set to 3. With 4-bit counts, saturation at 15 is reached within about twenty event pulses, so the no-wrap rule is tested directly rather than left untested behind a 16-bit limit. Three interrupt sources let the bench check that one acknowledge clears several status bits at once, and that a source pulse arriving in the acknowledge cycle survives.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NUM_EV = 6;

  typedef enum logic [2:0] {
    EV_ALIGN_CHG = 3'd0,
    EV_ALIGN_LOSS = 3'd1,
    EV_BIPOLAR = 3'd2,
    EV_CRC = 3'd3,
    EV_SEV_FRAME = 3'd4,
    EV_MF_SYNC = 3'd5
  } ev_idx_e;

  localparam int B_SWRST = 0;
  localparam int B_ACK = 1;
  localparam int B_SUSP = 2;
  localparam int B_CCLR = 3;
  localparam int B_SMPL = 4;
  localparam int B_LOSSEL = 5;

  typedef struct packed {
    logic los_sel;
    logic smp_en;
    logic cnt_clr;
    logic suspend;
  } ctl_t;

  function automatic logic los_drive(input logic sel, input logic los, input logic lof);
    return los | (lof & ~sel);
  endfunction
endpackage

// File: rtl/fsc_ev_chan.sv
module fsc_ev_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev,
  input  logic             tick,
  input  logic             smp_en,
  output logic [CNT_W-1:0] vis
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic e);
    return (e && v != TOP) ? v + ONE : v;
  endfunction

  logic [CNT_W-1:0] run_q, hold_q, run_nx;
  logic             capture;

  assign run_nx  = sat_inc(run_q, ev);
  assign capture = smp_en & tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hold_q <= '0;
    end else if (clr) begin
      run_q  <= '0;
      hold_q <= '0;
    end else if (capture) begin
      hold_q <= run_nx;
      run_q  <= '0;
    end else begin
      run_q <= run_nx;
    end
  end

  assign vis = smp_en ? hold_q : run_q;

  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == TOP && ev && !clr && !capture) |=> (run_q == TOP));
  assert_clr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (run_q == '0 && hold_q == '0));
  assert_tick_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !clr) |=> (run_q == '0));
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clr) |=> $stable(hold_q));
endmodule

// File: rtl/fsc_irq.sv
module fsc_irq #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clr,
  input  logic             ack,
  input  logic             suspend,
  input  logic [N_IRQ-1:0] src,
  output logic [N_IRQ-1:0] stat,
  output logic             irq_n,
  output logic             irq_oe
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat <= '0;
    else if (sw_clr) stat <= '0;
    else             stat <= (ack ? '0 : stat) | (suspend ? '0 : src);
  end

  assign pend   = (|stat) & ~suspend;
  assign irq_oe = pend;
  assign irq_n  = ~pend;

  assert_suspend_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> (!irq_oe && irq_n));
  assert_suspend_nosets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && !ack && !sw_clr) |=> (stat == $past(stat)));
  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && src == '0) |=> (stat == '0));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !sw_clr && !suspend) |=> ((stat & $past(src | stat)) == $past(src | stat)));
endmodule

// File: rtl/framer_stat_ctrl.sv
module framer_stat_ctrl
  import fsc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_IRQ = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_EV-1:0]       ev_pulse,
  input  logic                    sec_tick,
  input  logic [N_IRQ-1:0]        irq_src,
  input  logic                    los_state,
  input  logic                    lof_state,
  input  logic                    ctl_wr,
  input  logic [7:0]              ctl_wdata,
  output logic [7:0]              ctl_rdata,
  output logic [NUM_EV*CNT_W-1:0] cnt_flat,
  output logic [N_IRQ-1:0]        irq_stat,
  output logic                    irq_n,
  output logic                    irq_oe,
  output logic                    los_pin
);
  ctl_t ctl_q;
  logic sw_rst, ack_wr, chan_clr;

  assign sw_rst   = ctl_wr & ctl_wdata[B_SWRST];
  assign ack_wr   = ctl_wr & ctl_wdata[B_ACK] & ~sw_rst;
  assign chan_clr = ctl_q.cnt_clr | sw_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (sw_rst) ctl_q <= '0;
    else if (ctl_wr) begin
      ctl_q.los_sel <= ctl_wdata[B_LOSSEL];
      ctl_q.smp_en  <= ctl_wdata[B_SMPL];
      ctl_q.cnt_clr <= ctl_wdata[B_CCLR];
      ctl_q.suspend <= ctl_wdata[B_SUSP];
    end
  end

  always_comb begin
    ctl_rdata           = '0;
    ctl_rdata[B_SUSP]   = ctl_q.suspend;
    ctl_rdata[B_CCLR]   = ctl_q.cnt_clr;
    ctl_rdata[B_SMPL]   = ctl_q.smp_en;
    ctl_rdata[B_LOSSEL] = ctl_q.los_sel;
  end

  for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_chan
    fsc_ev_chan #(.CNT_W(CNT_W)) chan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (chan_clr),
      .ev     (ev_pulse[gi]),
      .tick   (sec_tick),
      .smp_en (ctl_q.smp_en),
      .vis    (cnt_flat[gi*CNT_W +: CNT_W])
    );
  end

  fsc_irq #(.N_IRQ(N_IRQ)) irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_clr  (sw_rst),
    .ack     (ack_wr),
    .suspend (ctl_q.suspend),
    .src     (irq_src),
    .stat    (irq_stat),
    .irq_n   (irq_n),
    .irq_oe  (irq_oe)
  );

  assign los_pin = los_drive(ctl_q.los_sel, los_state, lof_state);

  assert_sw_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (ctl_q == '0 && irq_stat == '0 && cnt_flat == '0));
  assert_rdata_selfclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[B_ACK] == 1'b0 && ctl_rdata[B_SWRST] == 1'b0));
  assert_los_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.los_sel |-> (los_pin == los_state));
endmodule

// File: tb/framer_stat_ctrl_tb_top.sv
module framer_stat_ctrl_tb_top;
  localparam int CW = 4;
  localparam int NI = 3;
  localparam int NE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NE-1:0] ev_pulse = '0;
  logic sec_tick = 1'b0;
  logic [NI-1:0] irq_src = '0;
  logic los_state = 1'b0, lof_state = 1'b0;
  logic ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic [NE*CW-1:0] cnt_flat;
  logic [NI-1:0] irq_stat;
  logic irq_n, irq_oe, los_pin;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  framer_stat_ctrl #(.CNT_W(CW), .N_IRQ(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .sec_tick(sec_tick),
    .irq_src(irq_src), .los_state(los_state), .lof_state(lof_state),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .cnt_flat(cnt_flat), .irq_stat(irq_stat), .irq_n(irq_n),
    .irq_oe(irq_oe), .los_pin(los_pin)
  );

  // {sel, los, lof, expected pin}
  localparam logic [3:0] LOS_VEC [8] = '{4'b0000, 4'b0011, 4'b0101, 4'b0111,
                                         4'b1000, 4'b1010, 4'b1101, 4'b1111};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cnt(input int i);
    return int'(cnt_flat[i*CW +: CW]);
  endfunction

  task automatic wr(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic ev(input int i, input logic tk);
    ev_pulse[i] = 1'b1; sec_tick = tk;
    @(negedge clk);
    ev_pulse = '0; sec_tick = 1'b0;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic src(input logic [NI-1:0] s, input logic do_ack);
    irq_src = s;
    if (do_ack) begin ctl_wr = 1'b1; ctl_wdata = 8'h02; end
    @(negedge clk);
    irq_src = '0; ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 counts", int'(cnt_flat == '0), 1);
    chk("R10 rdata", int'(ctl_rdata), 0);
    chk("R10 irq_oe", int'(irq_oe), 0);
    chk("R10 irq_n", int'(irq_n), 1);
    chk("R10 stat", int'(irq_stat), 0);

    // R9 table walk
    for (int k = 0; k < 8; k++) begin
      wr({2'b00, LOS_VEC[k][3], 5'b0});
      los_state = LOS_VEC[k][2]; lof_state = LOS_VEC[k][1];
      #1;
      chk("R9 los_pin", int'(los_pin), int'(LOS_VEC[k][0]));
    end
    los_state = 1'b0; lof_state = 1'b0;
    wr(8'h00);

    // R2 counting per index
    for (int i = 0; i < NE; i++)
      for (int r = 0; r <= i; r++) ev(i, 1'b0);
    for (int i = 0; i < NE; i++) chk("R2 count", cnt(i), i + 1);

    // R3 saturation
    for (int r = 0; r < 20; r++) ev(2, 1'b0);
    chk("R3 saturate", cnt(2), 15);
    chk("R3 neighbour", cnt(3), 4);

    // R1 soft reset with other bits present
    wr(8'h3D);
    chk("R1 counts", int'(cnt_flat == '0), 1);
    chk("R1 rdata", int'(ctl_rdata), 0);

    // R4 counter clear
    ev(1, 1'b0); ev(1, 1'b0);
    chk("R4 pre", cnt(1), 2);
    wr(8'h08);
    @(negedge clk);
    chk("R4 cleared", cnt(1), 0);
    ev(1, 1'b0);
    chk("R4 held", cnt(1), 0);
    wr(8'h00);
    ev(1, 1'b0);
    chk("R4 resume", cnt(1), 1);

    // R5 sampling mode
    wr(8'h01);
    wr(8'h10);
    ev(0, 1'b0); ev(0, 1'b0); ev(0, 1'b0);
    chk("R5 before tick", cnt(0), 0);
    ev(0, 1'b1);
    chk("R5 tick copy", cnt(0), 4);
    ev(0, 1'b0); ev(0, 1'b0);
    chk("R5 stable", cnt(0), 4);
    tick();
    chk("R5 restart", cnt(0), 2);
    tick();
    chk("R5 empty second", cnt(0), 0);
    wr(8'h01);

    // R6 sticky status
    src(3'b010, 1'b0);
    @(negedge clk);
    chk("R6 stat", int'(irq_stat), 2);
    chk("R6 irq_n", int'(irq_n), 0);
    chk("R6 irq_oe", int'(irq_oe), 1);
    src(3'b100, 1'b0);
    chk("R6 stat2", int'(irq_stat), 6);

    // R8 ack
    src(3'b000, 1'b1);
    chk("R8 cleared", int'(irq_stat), 0);
    chk("R8 oe", int'(irq_oe), 0);
    chk("R8 irq_n", int'(irq_n), 1);
    src(3'b010, 1'b0);
    src(3'b001, 1'b1);
    chk("R8 same-cycle src", int'(irq_stat), 1);
    chk("R8 rdata", int'(ctl_rdata[1]), 0);

    // R7 suspend
    wr(8'h04);
    chk("R7 oe", int'(irq_oe), 0);
    chk("R7 irq_n", int'(irq_n), 1);
    chk("R7 kept", int'(irq_stat), 1);
    src(3'b100, 1'b0);
    chk("R7 ignored", int'(irq_stat), 1);
    wr(8'h00);
    chk("R7 release", int'(irq_oe), 1);

    // R10 read-back / R8 ack bit not stored
    wr(8'h3C);
    chk("R10 readback", int'(ctl_rdata), 8'h3C);
    wr(8'h3E);
    chk("R8 readback", int'(ctl_rdata), 8'h3C);
    chk("R8 ack cleared", int'(irq_stat), 0);
    wr(8'h01);
    chk("R1 final rdata", int'(ctl_rdata), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule